// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is one self-contained timer channel built around a down-counter. A host programs it through two write strobes: one carries a 3-bit operating mode, the other a 16-bit initial count. From then on the channel runs on its own clock. A level-sensitive or edge-sensitive gate input controls it, depending on the mode, and it drives a single output waveform.

Six behaviours are available. The channel can raise a flag at terminal count, act as a gate-fired one-shot, or divide the clock by N with a one-clock low pulse. It can also produce a square wave of period N, or emit a one-clock low strobe that starts either from the count write or from a gate edge. The present count can be read at all times. The gate input is synchronised into the clock domain before it is used.

Top module: `pdt_channel`

## Requirements
- R1: After synchronous reset, `out` is 1 and `count_rd` is 0.
- R2: Mode 000 (terminal count): writing the mode drives `out` to 0. A count write of N leaves `count_rd`=N and `out`=0. With the gate high, the count drops by one on each later clock, and `out` goes to 1 on the N-th clock after the load edge. It then stays 1, with the count held at 0.
- R3: In modes 000, x10 and x11, the count holds while the synchronised gate is low. A 0-to-1 change on `gate_in` is seen as high by the count logic on the third clock edge after the change.
- R4: Mode 001 (one-shot): a count write alone does not start counting. On the third clock edge after `gate_in` rises, the count takes N and `out` goes to 0. `out` returns to 1 when the count reaches 0, so it is low for N clocks.
- R5: In modes 001 and 101, a gate rising edge that arrives while counting reloads the count with N.
- R6: Mode x10 (rate generator): the count sequence is N, N-1, ..., 1, then N again, so the period is N clocks. `out` is 0 only while the count is 1.
- R7: Mode x11 (square wave): the count reloads like R6. `out` is 1 while the count exceeds floor(N/2), which gives ceil(N/2) high clocks and floor(N/2) low clocks in each period.
- R8: Mode 100 (software strobe): `out` is 1 after the count write. The count falls each clock. `out` is 0 for exactly the one clock in which the count is 0, N clocks after the load edge, and then returns to 1.
- R9: Mode 101 (gate strobe): `out` stays 1 and nothing counts until a gate rising edge. That edge loads N, and `out` then gives the same single-clock low strobe as R8.
- R10: A count value of 0 means 65536. In mode 100, `count_rd` reads 0, then 0xFFFF, and then keeps falling; the strobe comes 65536 clocks after the load.
- R11: Mode bit 2 is ignored whenever bit 1 is set: 110 behaves as 010, and 111 behaves as 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_in | input | 1 | Asynchronous gate / trigger input |
| mode_wr | input | 1 | Strobe: take `mode_val` as the new mode |
| mode_val | input | 3 | Operating mode code |
| count_wr | input | 1 | Strobe: take `count_val` as the initial count |
| count_val | input | 16 | Initial count (0 means 65536) |
| out | output | 1 | Channel output waveform |
| count_rd | output | 16 | Current count value |

## Verification
Each mode is driven with its own gate pattern. A steady high gate separates free counting from gating. A gate held low across a count write shows that counting is frozen rather than slowed. A second gate edge in the middle of a one-shot shows a reload, which a channel that ignores late triggers would not produce. The square wave is run with an odd and an even N, so that a wrong split of the extra clock shows up. The rate generator is run with the aliased code 110, which tells true don't-care decoding apart from a plain equality compare. A zero count in strobe mode separates the 65536 interpretation from an immediate terminal count.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    typedef enum logic [2:0] {
        MODE_TC       = 3'd0,
        MODE_ONESHOT  = 3'd1,
        MODE_RATE     = 3'd2,
        MODE_SQUARE   = 3'd3,
        MODE_SWSTROBE = 3'd4,
        MODE_HWSTROBE = 3'd5
    } mode_e;

    // Bit 2 is a don't-care whenever bit 1 is set.
    function automatic mode_e decode_mode(input logic [2:0] raw);
        if (raw[1])
            return mode_e'({1'b0, raw[1:0]});
        else
            return mode_e'(raw);
    endfunction

    function automatic logic gate_levelled(input mode_e m);
        return (m == MODE_TC) || (m == MODE_RATE) || (m == MODE_SQUARE);
    endfunction

    function automatic logic gate_triggered(input mode_e m);
        return (m == MODE_ONESHOT) || (m == MODE_HWSTROBE);
    endfunction

endpackage

// File: rtl/pdt_gate_sync.sv
module pdt_gate_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_in,
    output logic gate_lvl,
    output logic gate_rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= gate_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], gate_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= gate_lvl;
    end

    assign gate_lvl  = sync_q[SYNC_STAGES-1];
    assign gate_rise = gate_lvl & ~prev_q;

    // R3: an edge indication lasts a single clock
    a_r3_rise_single: assert property (@(posedge clk) disable iff (rst)
        gate_rise |=> !gate_rise);

endmodule

// File: rtl/pdt_cfg.sv
module pdt_cfg
    import pdt_pkg::*;
#(
    parameter int EW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_wr,
    input  mode_e         mode_new,
    input  logic          count_wr,
    input  logic [EW-1:0] load_val,
    output mode_e         mode_q,
    output logic [EW-1:0] init_q,
    output logic          armed_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_TC;
            init_q  <= '0;
            armed_q <= 1'b0;
        end else if (mode_wr) begin
            mode_q  <= mode_new;
            armed_q <= 1'b0;
        end else if (count_wr) begin
            init_q  <= load_val;
            armed_q <= 1'b1;
        end
    end

    // R11: a mode write never leaves an undefined code behind
    a_r11_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (mode_q <= MODE_HWSTROBE));

endmodule

// File: rtl/pdt_engine.sv
module pdt_engine
    import pdt_pkg::*;
#(
    parameter int EW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_e         mode_q,
    input  mode_e         mode_new,
    input  logic [EW-1:0] init_q,
    input  logic          armed_q,
    input  logic          mode_wr,
    input  logic          count_wr,
    input  logic [EW-1:0] load_val,
    input  logic          gate_lvl,
    input  logic          gate_rise,
    output logic [EW-1:0] cnt_q,
    output logic          out_q
);
    localparam logic [EW-1:0] ONE  = EW'(1);
    localparam logic [EW-1:0] ZERO = '0;

    logic          run_q;
    logic [EW-1:0] dec;
    logic [EW-1:0] wrap_nxt;
    logic [EW-1:0] half;
    logic          trig;

    assign dec      = cnt_q - ONE;
    assign wrap_nxt = (cnt_q == ONE) ? init_q : dec;
    assign half     = init_q >> 1;
    assign trig     = gate_rise & armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            out_q <= 1'b1;
        end else if (mode_wr) begin
            run_q <= 1'b0;
            out_q <= (mode_new != MODE_TC);
        end else if (count_wr) begin
            if (!gate_triggered(mode_q)) begin
                cnt_q <= load_val;
                run_q <= 1'b1;
                out_q <= (mode_q != MODE_TC);
            end
        end else begin
            unique case (mode_q)
                MODE_TC: begin
                    if (run_q && gate_lvl) begin
                        cnt_q <= dec;
                        if (cnt_q == ONE) begin
                            out_q <= 1'b1;
                            run_q <= 1'b0;
                        end
                    end
                end
                MODE_ONESHOT: begin
                    if (trig) begin
                        cnt_q <= init_q;
                        run_q <= 1'b1;
                        out_q <= 1'b0;
                    end else if (run_q) begin
                        cnt_q <= dec;
                        if (cnt_q == ONE) begin
                            out_q <= 1'b1;
                            run_q <= 1'b0;
                        end
                    end
                end
                MODE_RATE: begin
                    if (run_q && gate_lvl) begin
                        cnt_q <= wrap_nxt;
                        out_q <= (wrap_nxt != ONE);
                    end
                end
                MODE_SQUARE: begin
                    if (run_q && gate_lvl) begin
                        cnt_q <= wrap_nxt;
                        out_q <= (wrap_nxt > half);
                    end
                end
                default: begin
                    if (mode_q == MODE_HWSTROBE && trig) begin
                        cnt_q <= init_q;
                        run_q <= 1'b1;
                        out_q <= 1'b1;
                    end else if (run_q) begin
                        if (cnt_q == ZERO) begin
                            out_q <= 1'b1;
                            run_q <= 1'b0;
                        end else begin
                            cnt_q <= dec;
                            out_q <= (cnt_q != ONE);
                        end
                    end
                end
            endcase
        end
    end

    // R2: terminal-count output is sticky until the host writes again
    a_r2_tc_sticky: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TC && out_q && !mode_wr && !count_wr) |=> out_q);

    // R3: a low gate freezes the count in level-gated modes
    a_r3_gate_freeze: assert property (@(posedge clk) disable iff (rst)
        (gate_levelled(mode_q) && !gate_lvl && !mode_wr && !count_wr)
        |=> $stable(cnt_q));

    // R5: an accepted trigger restarts from the initial count
    a_r5_retrigger_load: assert property (@(posedge clk) disable iff (rst)
        (gate_triggered(mode_q) && trig && !mode_wr && !count_wr)
        |=> (cnt_q == $past(init_q)));

    // R6: rate generator low phase lasts one clock
    a_r6_rate_one_low: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RATE && !out_q && gate_lvl && !mode_wr && !count_wr)
        |=> out_q);

    // R7: square wave level follows the count against half the period
    a_r7_square_level: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SQUARE && run_q && gate_lvl && !mode_wr && !count_wr)
        |=> (out_q == (cnt_q > half)));

    // R8, R9: strobe low lasts one clock
    a_r8_strobe_one_low: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == MODE_SWSTROBE || mode_q == MODE_HWSTROBE) && !out_q
         && !mode_wr && !count_wr) |=> out_q);

endmodule

// File: rtl/pdt_channel.sv
module pdt_channel
    import pdt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_in,
    input  logic             mode_wr,
    input  logic [2:0]       mode_val,
    input  logic             count_wr,
    input  logic [CNT_W-1:0] count_val,
    output logic             out,
    output logic [CNT_W-1:0] count_rd
);
    localparam int EW = CNT_W + 1;

    mode_e         mode_new;
    mode_e         mode_q;
    logic [EW-1:0] load_val;
    logic [EW-1:0] init_q;
    logic [EW-1:0] cnt_q;
    logic          armed_q;
    logic          gate_lvl;
    logic          gate_rise;

    // R10: zero selects the full 2**CNT_W range
    assign load_val = {(count_val == '0), count_val};
    assign mode_new = decode_mode(mode_val);

    pdt_gate_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .gate_in   (gate_in),
        .gate_lvl  (gate_lvl),
        .gate_rise (gate_rise)
    );

    pdt_cfg #(.EW(EW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .mode_wr  (mode_wr),
        .mode_new (mode_new),
        .count_wr (count_wr),
        .load_val (load_val),
        .mode_q   (mode_q),
        .init_q   (init_q),
        .armed_q  (armed_q)
    );

    pdt_engine #(.EW(EW)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .mode_q    (mode_q),
        .mode_new  (mode_new),
        .init_q    (init_q),
        .armed_q   (armed_q),
        .mode_wr   (mode_wr),
        .count_wr  (count_wr),
        .load_val  (load_val),
        .gate_lvl  (gate_lvl),
        .gate_rise (gate_rise),
        .cnt_q     (cnt_q),
        .out_q     (out)
    );

    assign count_rd = cnt_q[CNT_W-1:0];

endmodule

// File: tb/pdt_channel_tb.sv
module pdt_channel_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gate_in = 1'b0;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_val = '0;
    logic        count_wr = 1'b0;
    logic [15:0] count_val = '0;
    logic        out;
    logic [15:0] count_rd;

    int n_chk  = 0;
    int n_fail = 0;

    pdt_channel u_dut (
        .clk       (clk),
        .rst       (rst),
        .gate_in   (gate_in),
        .mode_wr   (mode_wr),
        .mode_val  (mode_val),
        .count_wr  (count_wr),
        .count_val (count_val),
        .out       (out),
        .count_rd  (count_rd)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [2:0] m);
        mode_wr = 1'b1; mode_val = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic wr_count(input logic [15:0] n);
        count_wr = 1'b1; count_val = n;
        @(negedge clk);
        count_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 out", 32'(out), 1);
        chk("R1 count", 32'(count_rd), 0);
    endtask

    task automatic t_mode0;
        gate_in = 1'b1; tick(3);
        wr_mode(3'b000);
        chk("R2 out after mode", 32'(out), 0);
        wr_count(16'd5);
        chk("R2 count loaded", 32'(count_rd), 5);
        chk("R2 out after load", 32'(out), 0);
        tick(4);
        chk("R2 count 1", 32'(count_rd), 1);
        chk("R2 out before tc", 32'(out), 0);
        tick(1);
        chk("R2 out at tc", 32'(out), 1);
        tick(3);
        chk("R2 out sticky", 32'(out), 1);
        chk("R2 count held", 32'(count_rd), 0);
    endtask

    task automatic t_gate_hold;
        gate_in = 1'b0; tick(3);
        wr_count(16'd10);
        tick(5);
        chk("R3 frozen", 32'(count_rd), 10);
        gate_in = 1'b1;
        tick(2);
        chk("R3 sync latency", 32'(count_rd), 10);
        tick(1);
        chk("R3 resumes", 32'(count_rd), 9);
    endtask

    task automatic t_rate(input logic [2:0] code, input int n, input string tag);
        int c = n;
        wr_mode(code);
        wr_count(16'(n));
        chk({tag, " load"}, 32'(count_rd), 32'(n));
        for (int k = 0; k < 2 * n; k++) begin
            tick(1);
            c = (c == 1) ? n : c - 1;
            chk({tag, " count"}, 32'(count_rd), 32'(c));
            chk({tag, " out"}, 32'(out), 32'(c != 1));
        end
    endtask

    task automatic t_square(input int n);
        int c = n;
        int highs = 0;
        wr_mode(3'b011);
        wr_count(16'(n));
        chk("R7 out after load", 32'(out), 1);
        for (int k = 0; k < 2 * n; k++) begin
            tick(1);
            c = (c == 1) ? n : c - 1;
            chk("R7 level", 32'(out), 32'(c > n / 2));
            if (out) highs++;
        end
        chk("R7 high clocks", 32'(highs), 32'(2 * ((n + 1) / 2)));
    endtask

    task automatic t_swstrobe;
        wr_mode(3'b100);
        chk("R8 out after mode", 32'(out), 1);
        wr_count(16'd3);
        tick(2);
        chk("R8 count 1", 32'(count_rd), 1);
        chk("R8 out before", 32'(out), 1);
        tick(1);
        chk("R8 strobe low", 32'(out), 0);
        tick(1);
        chk("R8 strobe ends", 32'(out), 1);
        tick(3);
        chk("R8 stays high", 32'(out), 1);
    endtask

    task automatic t_zero_count;
        wr_mode(3'b100);
        wr_count(16'd0);
        chk("R10 reads 0", 32'(count_rd), 0);
        chk("R10 out", 32'(out), 1);
        tick(1);
        chk("R10 wraps", 32'(count_rd), 32'hFFFF);
        tick(65534);
        chk("R10 count 1", 32'(count_rd), 1);
        chk("R10 no early strobe", 32'(out), 1);
        tick(1);
        chk("R10 strobe", 32'(out), 0);
    endtask

    task automatic t_oneshot;
        gate_in = 1'b0; tick(3);
        wr_mode(3'b001);
        chk("R4 out after mode", 32'(out), 1);
        wr_count(16'd4);
        tick(3);
        chk("R4 no start on write", 32'(out), 1);
        gate_in = 1'b1;
        tick(2);
        chk("R4 not yet", 32'(out), 1);
        tick(1);
        chk("R4 low", 32'(out), 0);
        chk("R4 loaded", 32'(count_rd), 4);
        tick(3);
        chk("R4 still low", 32'(out), 0);
        tick(1);
        chk("R4 ends", 32'(out), 1);
        tick(2);
        chk("R4 waits", 32'(out), 1);
    endtask

    task automatic t_retrigger;
        gate_in = 1'b0; tick(3);
        wr_count(16'd8);
        gate_in = 1'b1; tick(3);
        chk("R5 first trigger", 32'(count_rd), 8);
        gate_in = 1'b0; tick(2);
        chk("R5 counting", 32'(count_rd), 6);
        gate_in = 1'b1; tick(3);
        chk("R5 reload", 32'(count_rd), 8);
        chk("R5 out low", 32'(out), 0);
        tick(7);
        chk("R5 extended", 32'(out), 0);
        tick(1);
        chk("R5 ends", 32'(out), 1);
    endtask

    task automatic t_hwstrobe;
        gate_in = 1'b0; tick(3);
        wr_mode(3'b101);
        wr_count(16'd3);
        tick(3);
        chk("R9 idle out", 32'(out), 1);
        gate_in = 1'b1; tick(3);
        chk("R9 loaded", 32'(count_rd), 3);
        chk("R9 out high", 32'(out), 1);
        tick(3);
        chk("R9 strobe", 32'(out), 0);
        tick(1);
        chk("R9 strobe ends", 32'(out), 1);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_mode0();
        t_gate_hold();
        t_rate(3'b010, 4, "R6");
        t_rate(3'b110, 3, "R11");
        t_square(5);
        t_square(4);
        t_swstrobe();
        t_zero_count();
        t_oneshot();
        t_retrigger();
        t_hwstrobe();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule